// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock with Match Alarm

This peripheral keeps a 32-bit count of seconds and raises one interrupt when the count reaches a programmed value. It sits on a simple 32-bit register bus. A one-cycle pulse on `sec_tick` marks each elapsed second. That pulse comes from a divider outside the block.

Software can do four things. It can set the current time by writing the load register. It can arm the alarm by writing the match register. It can gate the interrupt with a mask bit. It can acknowledge the alarm through a write-only clear register. A bank of identification bytes at the top of the address window lets a driver confirm what it is talking to.

The visible count is the sum of two values: a stored offset and an elapsed-seconds counter. A load write rewrites the offset, so the count becomes exactly the written value.

The alarm status is a two-state machine:
- **ALM_CLEAR** moves to **ALM_RAISED** on a match event.
- **ALM_RAISED** returns to **ALM_CLEAR** on a clear request, but only when no match event happens in the same cycle.

A match event is either of these:
- a match-register write whose value equals the current count;
- a tick whose incremented count equals the stored match value.

Register word offsets (byte address, `bus_addr[1:0]` must be zero):

| Offset | Register | Access |
|---|---|---|
| 0x000 | count | read only |
| 0x004 | match | read/write |
| 0x008 | load | read/write |
| 0x00C | control (bit 0) | read/write |
| 0x010 | mask (bit 0) | read/write |
| 0x014 | raw status (bit 0) | read only |
| 0x018 | masked status (bit 0) | read only |
| 0x01C | clear | write only |
| 0xFE0–0xFFC | identification bytes | read only |

Top module: `rtc_match_top`

## Requirements
- R1: After reset, all of the following are zero: count, match, load, control, mask and raw status. `alarm_irq` is low.
- R2: Each `sec_tick` pulse adds one to the count, and 0xFFFFFFFF wraps to 0x00000000.
- R3: A write of V to offset 0x008 makes the count read V in the next cycle, and offset 0x008 reads back V. Later ticks count on from V.
- R4: Offset 0x004 reads back the written match value. Raw status (offset 0x014, bit 0) sets on the tick whose incremented count equals the match value. A match value below the count therefore fires only after the counter wraps.
- R5: A write to offset 0x004 whose value equals the current count sets raw status in the next cycle, with no tick needed.
- R6: The bits of offsets 0x00C and 0x010 are handled as follows:
  - Each keeps only bit 0, and bits 31:1 read zero.
  - Masked status (offset 0x018) reads raw status AND mask bit 0.
  - `alarm_irq` equals masked status bit 0.
- R7: Writing bit 0 = 1 to offset 0x01C clears raw status. A clear write with bit 0 = 0 has no effect. A clear that coincides with a match event leaves raw status set.
- R8: Offset 0x01C reads zero. Writes to offsets 0x000, 0x014 and 0x018 change nothing.
- R9: Offsets 0xFE0, 0xFE4, … 0xFFC read, in that order, the bytes 0x31, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in bits 7:0, with zero above.
- R10: The following accesses read zero and change no state:
  - offsets 0x020 to 0xFDF;
  - any address with `bus_addr[1:0]` nonzero.
- R11: Raw status stays set across further ticks until a clear write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sec_tick | input | 1 | One-cycle pulse per elapsed second |
| bus_sel | input | 1 | Bus access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| alarm_irq | output | 1 | Masked alarm interrupt |

## Verification
The bench targets the following corner cases:
- **Wrap-around.** A match value below the count must stay silent until the counter wraps. A design that compared with a plain greater-or-equal test would fire at once.
- **Immediate match.** A match written equal to the present count must raise status without any tick. A design that only compared on ticks would wait a full counter period.
- **Clear racing a match.** A clear arriving in the same cycle as a match event must lose. Giving the clear priority would drop an alarm.
- **Ignored accesses.** Writes to read-only and undefined offsets must leave the count, the match value and the status as they were. A loose decoder would corrupt them.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef enum logic [2:0] {
        REG_COUNT  = 3'd0,
        REG_MATCH  = 3'd1,
        REG_LOAD   = 3'd2,
        REG_CTRL   = 3'd3,
        REG_MASK   = 3'd4,
        REG_RAW    = 3'd5,
        REG_MASKED = 3'd6,
        REG_CLEAR  = 3'd7
    } reg_idx_e;

    typedef enum logic {
        ALM_CLEAR  = 1'b0,
        ALM_RAISED = 1'b1
    } alm_state_e;

    // Identification bytes, one per word, lowest address first.
    function automatic logic [7:0] id_byte(input logic [2:0] idx);
        logic [7:0] b;
        case (idx)
            3'd0:    b = 8'h31;
            3'd1:    b = 8'h10;
            3'd2:    b = 8'h14;
            3'd3:    b = 8'h00;
            3'd4:    b = 8'h0D;
            3'd5:    b = 8'hF0;
            3'd6:    b = 8'h05;
            default: b = 8'hB1;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         load_we,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count_o
);

    logic [W-1:0] offset_q, offset_d;
    logic [W-1:0] elapsed_q, elapsed_d;

    always_comb begin
        elapsed_d = elapsed_q + (tick ? W'(1) : W'(0));
        offset_d  = load_we ? (load_val - elapsed_d) : offset_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            offset_q  <= '0;
            elapsed_q <= '0;
        end else begin
            offset_q  <= offset_d;
            elapsed_q <= elapsed_d;
        end
    end

    assign count_o = offset_q + elapsed_q;

    AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load_we) |=> count_o == $past(count_o) + W'(1)); // R2

    AST_LOAD_SET: assert property (@(posedge clk) disable iff (!rst_n)
        load_we |=> count_o == $past(load_val)); // R3

endmodule

// File: rtl/rtc_alarm_fsm.sv
module rtc_alarm_fsm
    import rtc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         load_we,
    input  logic [W-1:0] count,
    input  logic [W-1:0] match_q,
    input  logic         match_we,
    input  logic [W-1:0] match_val,
    input  logic         clear_req,
    output logic         raw_o
);

    alm_state_e state_q, state_d;
    logic       hit_on_write;
    logic       hit_on_tick;
    logic       alarm_event;

    assign hit_on_write = match_we && (match_val == count);
    assign hit_on_tick  = tick && !load_we && ((count + W'(1)) == match_q);
    assign alarm_event  = hit_on_write || hit_on_tick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ALM_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ALM_CLEAR: begin
                if (alarm_event) state_d = ALM_RAISED;
            end
            ALM_RAISED: begin
                if (clear_req && !alarm_event) state_d = ALM_CLEAR;
            end
        endcase
    end

    always_comb begin
        raw_o = (state_q == ALM_RAISED);
    end

    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_event |=> raw_o); // R4

    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_req && !alarm_event) |=> !raw_o); // R7

    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_o && !clear_req) |=> raw_o); // R11

endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
    import rtc_pkg::*;
#(
    parameter int W      = 32,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    input  logic [W-1:0]      count,
    input  logic              raw,
    output logic [W-1:0]      match_q,
    output logic              mask_q,
    output logic              load_we,
    output logic [W-1:0]      load_val,
    output logic              match_we,
    output logic [W-1:0]      match_val,
    output logic              clear_req,
    output logic [W-1:0]      bus_rdata
);

    localparam int HI_W = ADDR_W - 5;

    logic [W-1:0] load_q;
    logic         ctrl_q;
    logic         aligned;
    logic         in_ctrl;
    logic         in_id;
    logic         wr_en;
    logic         rd_en;
    reg_idx_e     word;
    logic [2:0]   id_idx;

    assign aligned = (bus_addr[1:0] == 2'b00);
    assign in_ctrl = aligned && (bus_addr[ADDR_W-1:5] == {HI_W{1'b0}});
    assign in_id   = aligned && (bus_addr[ADDR_W-1:5] == {HI_W{1'b1}});
    assign word    = reg_idx_e'(bus_addr[4:2]);
    assign id_idx  = bus_addr[4:2];
    assign wr_en   = bus_sel && bus_write && in_ctrl;
    assign rd_en   = bus_sel && !bus_write;

    assign load_we   = wr_en && (word == REG_LOAD);
    assign load_val  = bus_wdata;
    assign match_we  = wr_en && (word == REG_MATCH);
    assign match_val = bus_wdata;
    assign clear_req = wr_en && (word == REG_CLEAR) && bus_wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            match_q <= '0;
            load_q  <= '0;
            ctrl_q  <= 1'b0;
            mask_q  <= 1'b0;
        end else if (wr_en) begin
            unique case (word)
                REG_MATCH: match_q <= bus_wdata;
                REG_LOAD:  load_q  <= bus_wdata;
                REG_CTRL:  ctrl_q  <= bus_wdata[0];
                REG_MASK:  mask_q  <= bus_wdata[0];
                default:   ;
            endcase
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_en && in_ctrl) begin
            unique case (word)
                REG_COUNT:  bus_rdata = count;
                REG_MATCH:  bus_rdata = match_q;
                REG_LOAD:   bus_rdata = load_q;
                REG_CTRL:   bus_rdata = W'(ctrl_q);
                REG_MASK:   bus_rdata = W'(mask_q);
                REG_RAW:    bus_rdata = W'(raw);
                REG_MASKED: bus_rdata = W'(raw & mask_q);
                REG_CLEAR:  bus_rdata = '0;
            endcase
        end else if (rd_en && in_id) begin
            bus_rdata = W'(id_byte(id_idx));
        end
    end

    AST_MATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !match_we |=> $stable(match_q)); // R10

endmodule

// File: rtl/rtc_match_top.sv
module rtc_match_top #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic              bus_sel,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              alarm_irq
);

    logic [DATA_W-1:0] count;
    logic [DATA_W-1:0] match_q;
    logic [DATA_W-1:0] load_val;
    logic [DATA_W-1:0] match_val;
    logic              mask_q;
    logic              load_we;
    logic              match_we;
    logic              clear_req;
    logic              raw;

    rtc_sec_counter #(.W(DATA_W)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (sec_tick),
        .load_we  (load_we),
        .load_val (load_val),
        .count_o  (count)
    );

    rtc_alarm_fsm #(.W(DATA_W)) u_alarm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (sec_tick),
        .load_we   (load_we),
        .count     (count),
        .match_q   (match_q),
        .match_we  (match_we),
        .match_val (match_val),
        .clear_req (clear_req),
        .raw_o     (raw)
    );

    rtc_regfile #(.W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .count     (count),
        .raw       (raw),
        .match_q   (match_q),
        .mask_q    (mask_q),
        .load_we   (load_we),
        .load_val  (load_val),
        .match_we  (match_we),
        .match_val (match_val),
        .clear_req (clear_req),
        .bus_rdata (bus_rdata)
    );

    assign alarm_irq = raw & mask_q;

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_q |-> !alarm_irq); // R6

endmodule

// File: tb/tb_rtc_match_top.sv
module tb_rtc_match_top;

    localparam int DW = 32;
    localparam int AW = 12;

    localparam logic [1:0] OP_WR  = 2'd0;
    localparam logic [1:0] OP_RD  = 2'd1;
    localparam logic [1:0] OP_TK  = 2'd2;
    localparam logic [1:0] OP_IRQ = 2'd3;

    typedef struct packed {
        logic [1:0]  op;
        logic [11:0] addr;
        logic [31:0] data;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 57;
    localparam vec_t VEC [NV] = '{
        '{OP_RD, 12'h000, 32'h0,        8'd1},  // R1 count
        '{OP_RD, 12'h004, 32'h0,        8'd1},  // R1 match
        '{OP_RD, 12'h014, 32'h0,        8'd1},  // R1 raw
        '{OP_RD, 12'h010, 32'h0,        8'd1},  // R1 mask
        '{OP_IRQ,12'h000, 32'h0,        8'd1},  // R1 irq
        '{OP_WR, 12'h008, 32'h100,      8'd0},
        '{OP_RD, 12'h000, 32'h100,      8'd3},  // R3 count loaded
        '{OP_RD, 12'h008, 32'h100,      8'd3},  // R3 load readback
        '{OP_TK, 12'h000, 32'h0,        8'd0},
        '{OP_TK, 12'h000, 32'h0,        8'd0},
        '{OP_RD, 12'h000, 32'h102,      8'd2},  // R2 two ticks
        '{OP_WR, 12'h004, 32'h104,      8'd0},
        '{OP_RD, 12'h004, 32'h104,      8'd4},  // R4 match readback
        '{OP_TK, 12'h000, 32'h0,        8'd0},
        '{OP_RD, 12'h014, 32'h0,        8'd4},  // R4 not yet
        '{OP_TK, 12'h000, 32'h0,        8'd0},
        '{OP_RD, 12'h014, 32'h1,        8'd4},  // R4 fired
        '{OP_RD, 12'h018, 32'h0,        8'd6},  // R6 masked off
        '{OP_IRQ,12'h000, 32'h0,        8'd6},  // R6
        '{OP_WR, 12'h010, 32'hFFFFFFFF, 8'd0},
        '{OP_RD, 12'h010, 32'h1,        8'd6},  // R6 mask bit0 only
        '{OP_RD, 12'h018, 32'h1,        8'd6},  // R6
        '{OP_IRQ,12'h000, 32'h1,        8'd6},  // R6
        '{OP_TK, 12'h000, 32'h0,        8'd0},
        '{OP_RD, 12'h014, 32'h1,        8'd11}, // R11 sticky
        '{OP_WR, 12'h01C, 32'hFFFFFFFE, 8'd0},
        '{OP_RD, 12'h014, 32'h1,        8'd7},  // R7 bit0 zero ignored
        '{OP_WR, 12'h01C, 32'h1,        8'd0},
        '{OP_RD, 12'h014, 32'h0,        8'd7},  // R7 cleared
        '{OP_IRQ,12'h000, 32'h0,        8'd7},  // R7
        '{OP_RD, 12'h01C, 32'h0,        8'd8},  // R8 clear reads zero
        '{OP_WR, 12'h000, 32'hDEAD,     8'd0},
        '{OP_RD, 12'h000, 32'h105,      8'd8},  // R8 count untouched
        '{OP_WR, 12'h014, 32'h1,        8'd0},
        '{OP_RD, 12'h014, 32'h0,        8'd8},  // R8 raw untouched
        '{OP_WR, 12'h018, 32'h1,        8'd0},
        '{OP_RD, 12'h014, 32'h0,        8'd8},  // R8
        '{OP_WR, 12'h00C, 32'h3,        8'd0},
        '{OP_RD, 12'h00C, 32'h1,        8'd6},  // R6 control bit0
        '{OP_WR, 12'h004, 32'h105,      8'd0},
        '{OP_RD, 12'h014, 32'h1,        8'd5},  // R5 immediate
        '{OP_WR, 12'h01C, 32'h1,        8'd0},
        '{OP_RD, 12'hFE0, 32'h31,       8'd9},  // R9
        '{OP_RD, 12'hFE4, 32'h10,       8'd9},
        '{OP_RD, 12'hFE8, 32'h14,       8'd9},
        '{OP_RD, 12'hFEC, 32'h00,       8'd9},
        '{OP_RD, 12'hFF0, 32'h0D,       8'd9},
        '{OP_RD, 12'hFF4, 32'hF0,       8'd9},
        '{OP_RD, 12'hFF8, 32'h05,       8'd9},
        '{OP_RD, 12'hFFC, 32'hB1,       8'd9},
        '{OP_RD, 12'h020, 32'h0,        8'd10}, // R10
        '{OP_WR, 12'h020, 32'hFFFF,     8'd0},
        '{OP_RD, 12'h000, 32'h105,      8'd10}, // R10
        '{OP_RD, 12'h004, 32'h105,      8'd10}, // R10
        '{OP_RD, 12'h800, 32'h0,        8'd10}, // R10
        '{OP_RD, 12'h002, 32'h0,        8'd10}, // R10 misaligned
        '{OP_RD, 12'h014, 32'h0,        8'd10}  // R10
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sec_tick = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_write = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          alarm_irq;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;

    always #2 clk = ~clk;

    rtc_match_top #(.DATA_W(DW), .ADDR_W(AW)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sec_tick  (sec_tick),
        .bus_sel   (bus_sel),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .alarm_irq (alarm_irq)
    );

    task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input int req, input logic [31:0] exp);
        bus_sel = 1'b1; bus_write = 1'b0; bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic tk();
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();

        for (int i = 0; i < NV; i++) begin
            case (VEC[i].op)
                OP_WR:   wr(VEC[i].addr, VEC[i].data);
                OP_RD:   rd(VEC[i].addr, int'(VEC[i].req), VEC[i].data);
                OP_TK:   tk();
                default: begin
                    #1;
                    check(int'(VEC[i].req), {31'b0, alarm_irq}, VEC[i].data);
                    @(negedge clk);
                end
            endcase
        end

        // R2 / R4: wrap-around, match below count fires after wrap
        wr(12'h008, 32'hFFFFFFFE);
        wr(12'h004, 32'h00000001);
        rd(12'h014, 4, 32'h0);
        tk();
        rd(12'h000, 2, 32'hFFFFFFFF);
        tk();
        rd(12'h000, 2, 32'h00000000);
        rd(12'h014, 4, 32'h0);
        tk();
        rd(12'h014, 4, 32'h1);
        wr(12'h01C, 32'h1);

        // R7: clear coincident with a match event, match wins
        wr(12'h008, 32'h0000000A);
        wr(12'h004, 32'h0000000B);
        rd(12'h014, 7, 32'h0);
        sec_tick = 1'b1;
        bus_sel = 1'b1; bus_write = 1'b1; bus_addr = 12'h01C; bus_wdata = 32'h1;
        @(negedge clk);
        sec_tick = 1'b0; bus_sel = 1'b0; bus_write = 1'b0;
        rd(12'h014, 7, 32'h1);
        rd(12'h000, 7, 32'h0000000B);

        // R1: reset mid-run restores zero state
        wr(12'h00C, 32'h1);
        do_reset();
        rd(12'h000, 1, 32'h0);
        rd(12'h004, 1, 32'h0);
        rd(12'h008, 1, 32'h0);
        rd(12'h00C, 1, 32'h0);
        rd(12'h010, 1, 32'h0);
        rd(12'h014, 1, 32'h0);
        #1;
        check(1, {31'b0, alarm_irq}, 32'h0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule